// File: doc/BRIEF.md
# Obstacle-Aware Route Decision for a 2-D Mesh Router

This block decides, for one router of a two-dimensional mesh network, which output port a packet header should take. It is given the router's own X/Y position, the destination X/Y and a one-bit detour mark carried in the header, the port the header arrived on, and one active line from each of the four neighbours. A neighbour whose line is low has been switched off because a placed module covers it, and it must never receive traffic. The block returns the chosen port and the updated detour mark.

With every relevant neighbour active the decision is dimension-ordered: correct X first, then Y, then deliver locally. When the preferred neighbour is off, the packet is turned perpendicular and marked. A marked packet keeps moving in the direction it is already travelling along the edge of the switched-off region. At the corner it turns back toward its target and the mark is dropped. The mark also forbids sending a packet back out of the port it came in on, which prevents two routers from passing one packet back and forth at an obstacle. Routers on the mesh border treat their outward neighbours as always-active package pins. A caller raises `req` with one header per cycle. The decision comes back registered, one cycle later, with `gnt`.

Top module: `detour_route_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `gnt` is 0, `out_port` is 5 (stall) and `stamp_out` is 0.
- R2: A cycle with `req` high produces `gnt` high on the next cycle, carrying that header's decision. A cycle with `req` low produces `gnt` low on the next cycle, and `out_port` and `stamp_out` keep their values.
- R3: A header whose destination equals the router's own position gets port 0 (local) with the mark cleared. Any other header never gets port 0.
- R4: Port codes: 0 local, 1 east (+X), 2 west, 3 north (+Y), 4 south, 5 stall. For an unmarked header (or one that arrived on port 0), if X differs the packet goes east or west toward the destination column. If X matches it goes north or south toward the destination row. In both cases the mark is cleared when that neighbour is available.
- R5: If the X-correcting neighbour is unavailable, the packet goes north when destination Y >= own Y and south otherwise (the other vertical port as fallback), with the mark set.
- R6: If X already matches and the Y-correcting neighbour is unavailable, the packet goes sideways to the side chosen by parameter `SIDE_EAST` (east when 1, the default), or to the other side as fallback, with the mark set.
- R7: A marked header that arrived on port 3 or 4 (moving along a vertical obstacle edge), with X still wrong, turns toward the destination column and clears the mark when that neighbour is available. Otherwise it keeps its direction of travel with the mark set.
- R8: A marked header that arrived on port 1 or 2 (moving along a horizontal obstacle edge), with Y still wrong, turns toward the destination row and clears the mark when that neighbour is available. Otherwise it keeps its direction of travel with the mark set.
- R9: A marked header that arrived on ports 1 to 4 is never sent back out of its arrival port.
- R10: `nbr_act` bit 0 is east, bit 1 west, bit 2 north, bit 3 south. A port 1 to 4 is chosen only when its bit is 1, or when that side faces outward from the mesh border (own X = `MESH_X`-1 for east, 0 for west, own Y = `MESH_Y`-1 for north, 0 for south).
- R11: When no candidate port is available, the answer is 5 (stall) and the mark is returned unchanged.
- R12: In a mesh where a rectangular block of routers, kept one ring away from the border, is switched off, repeated decisions carry every packet between any two active routers to its destination within 4·(`MESH_X`+`MESH_Y`) hops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | A header is presented this cycle |
| own_x | input | CW | Router X position |
| own_y | input | CW | Router Y position |
| dst_x | input | CW | Header destination X |
| dst_y | input | CW | Header destination Y |
| stamp_in | input | 1 | Header detour mark |
| arr_port | input | 3 | Port the header arrived on (0..4) |
| nbr_act | input | 4 | Neighbour active lines: E, W, N, S in bits 0..3 |
| gnt | output | 1 | Decision valid, one cycle after `req` |
| out_port | output | 3 | Chosen output port code (0..5) |
| stamp_out | output | 1 | Updated detour mark |

## Verification
The only state is the output register, so a wrong comparison, a wrong availability mask or a wrong candidate order shows at `out_port` in the grant cycle that follows the offending request. A wrongly set or cleared mark often looks correct for that hop. It shows up a few hops later, as a packet that reverses at an obstacle, circles, or runs past the hop bound. For that reason the bench walks whole routes through a mesh with a switched-off block, besides comparing single decisions.

// File: rtl/dru_pkg.sv
package dru_pkg;

  localparam int NDIR = 4;

  typedef enum logic [2:0] {
    P_LOCAL = 3'd0,
    P_EAST  = 3'd1,
    P_WEST  = 3'd2,
    P_NORTH = 3'd3,
    P_SOUTH = 3'd4,
    P_STALL = 3'd5
  } port_e;

  function automatic port_e opp_dir(input port_e p);
    case (p)
      P_EAST:  opp_dir = P_WEST;
      P_WEST:  opp_dir = P_EAST;
      P_NORTH: opp_dir = P_SOUTH;
      P_SOUTH: opp_dir = P_NORTH;
      default: opp_dir = p;
    endcase
  endfunction

  function automatic logic dir_ok(input logic [NDIR-1:0] eff, input port_e p);
    case (p)
      P_EAST:  dir_ok = eff[0];
      P_WEST:  dir_ok = eff[1];
      P_NORTH: dir_ok = eff[2];
      P_SOUTH: dir_ok = eff[3];
      default: dir_ok = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dru_coord_cmp.sv
module dru_coord_cmp #(
  parameter int CW = 4
) (
  input  logic [CW-1:0] own_c,
  input  logic [CW-1:0] dst_c,
  output logic          eq,
  output logic          gt
);
  always_comb begin
    eq = (dst_c == own_c);
    gt = (dst_c >  own_c);
  end
endmodule

// File: rtl/dru_edge_mask.sv
module dru_edge_mask
  import dru_pkg::*;
#(
  parameter int CW     = 4,
  parameter int MESH_X = 16,
  parameter int MESH_Y = 16
) (
  input  logic [CW-1:0]   own_x,
  input  logic [CW-1:0]   own_y,
  input  logic [NDIR-1:0] nbr_act,
  input  logic            stamp_in,
  input  logic [2:0]      arr_port,
  output logic [NDIR-1:0] eff
);
  localparam logic [CW-1:0] XLAST = CW'(MESH_X - 1);
  localparam logic [CW-1:0] YLAST = CW'(MESH_Y - 1);

  logic [NDIR-1:0] at_edge;
  logic            no_return;

  always_comb begin
    at_edge[0] = (own_x == XLAST);
    at_edge[1] = (own_x == '0);
    at_edge[2] = (own_y == YLAST);
    at_edge[3] = (own_y == '0);
    no_return  = stamp_in && (arr_port != 3'(P_LOCAL));
  end

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    always_comb begin
      eff[d] = (nbr_act[d] | at_edge[d]) & ~(no_return && (arr_port == 3'(d + 1)));
    end
  end
endmodule

// File: rtl/dru_decide.sv
module dru_decide
  import dru_pkg::*;
#(
  parameter bit SIDE_EAST = 1'b1
) (
  input  logic            x_eq,
  input  logic            x_gt,
  input  logic            y_eq,
  input  logic            y_gt,
  input  logic            stamp_in,
  input  logic [2:0]      arr_port,
  input  logic [NDIR-1:0] eff,
  output port_e           port_nx,
  output logic            stamp_nx
);
  port_e hx, vy, up, side, arr, trv;
  port_e c0, c1, c2;
  logic  marked, trv_vert, trv_horz;

  always_comb begin
    hx       = x_gt ? P_EAST : P_WEST;
    vy       = y_gt ? P_NORTH : P_SOUTH;
    up       = (y_gt || y_eq) ? P_NORTH : P_SOUTH;
    side     = SIDE_EAST ? P_EAST : P_WEST;
    arr      = port_e'(arr_port);
    trv      = opp_dir(arr);
    marked   = stamp_in && (arr != P_LOCAL);
    trv_vert = (trv == P_NORTH) || (trv == P_SOUTH);
    trv_horz = (trv == P_EAST) || (trv == P_WEST);

    if (marked && trv_vert && !x_eq) begin
      c0 = hx;  c1 = trv;  c2 = opp_dir(hx);
    end else if (marked && trv_horz && !y_eq) begin
      c0 = vy;  c1 = trv;  c2 = opp_dir(vy);
    end else if (!x_eq) begin
      c0 = hx;  c1 = up;   c2 = opp_dir(up);
    end else begin
      c0 = vy;  c1 = side; c2 = opp_dir(side);
    end

    if (x_eq && y_eq) begin
      port_nx  = P_LOCAL;
      stamp_nx = 1'b0;
    end else if (dir_ok(eff, c0)) begin
      port_nx  = c0;
      stamp_nx = 1'b0;
    end else if (dir_ok(eff, c1)) begin
      port_nx  = c1;
      stamp_nx = 1'b1;
    end else if (dir_ok(eff, c2)) begin
      port_nx  = c2;
      stamp_nx = 1'b1;
    end else begin
      port_nx  = P_STALL;
      stamp_nx = stamp_in;
    end
  end
endmodule

// File: rtl/detour_route_unit.sv
module detour_route_unit
  import dru_pkg::*;
#(
  parameter int CW        = 4,
  parameter int MESH_X    = 16,
  parameter int MESH_Y    = 16,
  parameter bit SIDE_EAST = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [CW-1:0] own_x,
  input  logic [CW-1:0] own_y,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  input  logic          stamp_in,
  input  logic [2:0]    arr_port,
  input  logic [3:0]    nbr_act,
  output logic          gnt,
  output logic [2:0]    out_port,
  output logic          stamp_out
);
  logic            x_eq, x_gt, y_eq, y_gt;
  logic [NDIR-1:0] eff;
  port_e           port_nx;
  logic            stamp_nx;

  dru_coord_cmp #(.CW(CW)) cmp_x_i (
    .own_c(own_x), .dst_c(dst_x), .eq(x_eq), .gt(x_gt)
  );

  dru_coord_cmp #(.CW(CW)) cmp_y_i (
    .own_c(own_y), .dst_c(dst_y), .eq(y_eq), .gt(y_gt)
  );

  dru_edge_mask #(.CW(CW), .MESH_X(MESH_X), .MESH_Y(MESH_Y)) mask_i (
    .own_x(own_x), .own_y(own_y), .nbr_act(nbr_act),
    .stamp_in(stamp_in), .arr_port(arr_port), .eff(eff)
  );

  dru_decide #(.SIDE_EAST(SIDE_EAST)) dec_i (
    .x_eq(x_eq), .x_gt(x_gt), .y_eq(y_eq), .y_gt(y_gt),
    .stamp_in(stamp_in), .arr_port(arr_port), .eff(eff),
    .port_nx(port_nx), .stamp_nx(stamp_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt       <= 1'b0;
      out_port  <= 3'(P_STALL);
      stamp_out <= 1'b0;
    end else begin
      gnt <= req;
      if (req) begin
        out_port  <= 3'(port_nx);
        stamp_out <= stamp_nx;
      end
    end
  end
endmodule

// File: rtl/dru_checker.sv
module dru_checker #(
  parameter int CW     = 4,
  parameter int MESH_X = 16,
  parameter int MESH_Y = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req,
  input logic [CW-1:0] own_x,
  input logic [CW-1:0] own_y,
  input logic [CW-1:0] dst_x,
  input logic [CW-1:0] dst_y,
  input logic          stamp_in,
  input logic [2:0]    arr_port,
  input logic [3:0]    nbr_act,
  input logic          gnt,
  input logic [2:0]    out_port,
  input logic          stamp_out
);
  localparam logic [CW-1:0] XL = CW'(MESH_X - 1);
  localparam logic [CW-1:0] YL = CW'(MESH_Y - 1);

  AST_GNT_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req |=> gnt); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !req |=> (!gnt && $stable(out_port) && $stable(stamp_out))); // R2

  AST_LOCAL_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    (req && dst_x == own_x && dst_y == own_y) |=> (out_port == 3'd0 && !stamp_out)); // R3

  AST_NO_LOCAL_ELSEWHERE: assert property (@(posedge clk) disable iff (rst)
    (req && (dst_x != own_x || dst_y != own_y)) |=> (out_port != 3'd0)); // R3

  AST_NO_BOUNCE: assert property (@(posedge clk) disable iff (rst)
    (req && stamp_in && arr_port != 3'd0) |=> (out_port != $past(arr_port))); // R9

  AST_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (rst)
    req |=> ((out_port != 3'd1 || $past(nbr_act[0]) || $past(own_x) == XL) &&
             (out_port != 3'd2 || $past(nbr_act[1]) || $past(own_x) == '0) &&
             (out_port != 3'd3 || $past(nbr_act[2]) || $past(own_y) == YL) &&
             (out_port != 3'd4 || $past(nbr_act[3]) || $past(own_y) == '0))); // R10

  AST_STALL_KEEPS_MARK: assert property (@(posedge clk) disable iff (rst)
    req |=> (out_port != 3'd5 || stamp_out == $past(stamp_in))); // R11

  AST_PORT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    gnt |-> (out_port <= 3'd5)); // R4
endmodule

bind detour_route_unit dru_checker #(.CW(CW), .MESH_X(MESH_X), .MESH_Y(MESH_Y)) chk_i (
  .clk(clk), .rst(rst), .req(req), .own_x(own_x), .own_y(own_y),
  .dst_x(dst_x), .dst_y(dst_y), .stamp_in(stamp_in), .arr_port(arr_port),
  .nbr_act(nbr_act), .gnt(gnt), .out_port(out_port), .stamp_out(stamp_out)
);

// File: tb/detour_route_unit_tb_top.sv
module detour_route_unit_tb_top;
  localparam int CW = 4;
  localparam int MX = 6;
  localparam int MY = 6;
  localparam int HOP_MAX = 4 * (MX + MY);
  localparam int BX0 = 2, BX1 = 3, BY0 = 2, BY1 = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic [CW-1:0] own_x = '0, own_y = '0, dst_x = '0, dst_y = '0;
  logic          stamp_in = 1'b0;
  logic [2:0]    arr_port = 3'd0;
  logic [3:0]    nbr_act = 4'h0;
  logic          gnt;
  logic [2:0]    out_port;
  logic          stamp_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  detour_route_unit #(.CW(CW), .MESH_X(MX), .MESH_Y(MY), .SIDE_EAST(1'b1)) dut_i (
    .clk(clk), .rst(rst), .req(req), .own_x(own_x), .own_y(own_y),
    .dst_x(dst_x), .dst_y(dst_y), .stamp_in(stamp_in), .arr_port(arr_port),
    .nbr_act(nbr_act), .gnt(gnt), .out_port(out_port), .stamp_out(stamp_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] t_opp(input logic [2:0] p);
    case (p)
      3'd1: t_opp = 3'd2;
      3'd2: t_opp = 3'd1;
      3'd3: t_opp = 3'd4;
      3'd4: t_opp = 3'd3;
      default: t_opp = p;
    endcase
  endfunction

  function automatic bit t_ok(input logic [3:0] e, input logic [2:0] p);
    if (p >= 3'd1 && p <= 3'd4) t_ok = e[p - 3'd1];
    else t_ok = 1'b0;
  endfunction

  // Expected {mark, port} from the requirements R3..R11.
  function automatic logic [3:0] ref_route(input logic [3:0] ox, oy, dx, dy,
                                            input logic st, input logic [2:0] ar,
                                            input logic [3:0] na);
    logic [3:0] e;
    logic [2:0] hx, vy, up, t, c0, c1, c2;
    bit sv;
    e = na;
    if (ox == 4'(MX - 1)) e[0] = 1'b1;
    if (ox == 4'd0)       e[1] = 1'b1;
    if (oy == 4'(MY - 1)) e[2] = 1'b1;
    if (oy == 4'd0)       e[3] = 1'b1;
    sv = st && (ar != 3'd0);
    if (sv && ar >= 3'd1 && ar <= 3'd4) e[ar - 3'd1] = 1'b0;
    hx = (dx > ox) ? 3'd1 : 3'd2;
    vy = (dy > oy) ? 3'd3 : 3'd4;
    up = (dy >= oy) ? 3'd3 : 3'd4;
    t  = t_opp(ar);
    if (sv && (t == 3'd3 || t == 3'd4) && dx != ox) begin
      c0 = hx; c1 = t; c2 = t_opp(hx);
    end else if (sv && (t == 3'd1 || t == 3'd2) && dy != oy) begin
      c0 = vy; c1 = t; c2 = t_opp(vy);
    end else if (dx != ox) begin
      c0 = hx; c1 = up; c2 = t_opp(up);
    end else begin
      c0 = vy; c1 = 3'd1; c2 = 3'd2;
    end
    if (dx == ox && dy == oy) ref_route = {1'b0, 3'd0};
    else if (t_ok(e, c0))     ref_route = {1'b0, c0};
    else if (t_ok(e, c1))     ref_route = {1'b1, c1};
    else if (t_ok(e, c2))     ref_route = {1'b1, c2};
    else                      ref_route = {st, 3'd5};
  endfunction

  function automatic bit alive(input int x, input int y);
    alive = (x >= 0 && x < MX && y >= 0 && y < MY) &&
            !(x >= BX0 && x <= BX1 && y >= BY0 && y <= BY1);
  endfunction

  function automatic logic [3:0] nbrs_of(input int x, input int y);
    nbrs_of = {alive(x, y - 1), alive(x, y + 1), alive(x - 1, y), alive(x + 1, y)};
  endfunction

  task automatic route(input logic [3:0] ox, oy, dx, dy, input logic st,
                       input logic [2:0] ar, input logic [3:0] na,
                       output logic [2:0] p, output logic s, output logic g);
    @(negedge clk);
    own_x = ox; own_y = oy; dst_x = dx; dst_y = dy;
    stamp_in = st; arr_port = ar; nbr_act = na; req = 1'b1;
    @(negedge clk);
    p = out_port; s = stamp_out; g = gnt;
    req = 1'b0;
  endtask

  task automatic directed(input string tag, input logic [3:0] ox, oy, dx, dy,
                          input logic st, input logic [2:0] ar, input logic [3:0] na,
                          input logic [2:0] ep, input logic es);
    logic [2:0] p; logic s, g;
    route(ox, oy, dx, dy, st, ar, na, p, s, g);
    check(g == 1'b1, {tag, " grant"}, g, 1);
    check(p == ep, {tag, " port"}, p, ep);
    check(s == es, {tag, " mark"}, s, es);
  endtask

  initial begin
    logic [2:0] p, lastp;
    logic s, g, lasts;
    logic [3:0] exp;
    void'($urandom(32'h5eed_0042));

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(gnt == 1'b0, "R1 gnt in reset", gnt, 0);
    check(out_port == 3'd5, "R1 port in reset", out_port, 5);
    check(stamp_out == 1'b0, "R1 mark in reset", stamp_out, 0);
    rst = 1'b0;
    @(negedge clk);
    check(gnt == 1'b0 && out_port == 3'd5, "R1 after reset", out_port, 5);

    // Directed corner cases
    directed("R3 match", 4'd3, 4'd3, 4'd3, 4'd3, 1'b1, 3'd1, 4'hF, 3'd0, 1'b0);
    directed("R4 east", 4'd3, 4'd3, 4'd5, 4'd1, 1'b0, 3'd0, 4'hF, 3'd1, 1'b0);
    directed("R4 south", 4'd3, 4'd3, 4'd3, 4'd1, 1'b0, 3'd0, 4'hF, 3'd4, 1'b0);
    directed("R5 north", 4'd3, 4'd3, 4'd0, 4'd4, 1'b0, 3'd0, 4'b1101, 3'd3, 1'b1);
    directed("R5 equal row", 4'd3, 4'd3, 4'd0, 4'd3, 1'b0, 3'd0, 4'b1101, 3'd3, 1'b1);
    directed("R5 south", 4'd3, 4'd3, 4'd0, 4'd1, 1'b0, 3'd0, 4'b1101, 3'd4, 1'b1);
    directed("R6 side", 4'd3, 4'd3, 4'd3, 4'd0, 1'b0, 3'd0, 4'b0111, 3'd1, 1'b1);
    directed("R6 fallback", 4'd3, 4'd3, 4'd3, 4'd0, 1'b0, 3'd0, 4'b0110, 3'd2, 1'b1);
    directed("R7 keep", 4'd4, 4'd3, 4'd0, 4'd3, 1'b1, 3'd4, 4'b1101, 3'd3, 1'b1);
    directed("R7 corner", 4'd4, 4'd3, 4'd0, 4'd3, 1'b1, 3'd4, 4'hF, 3'd2, 1'b0);
    directed("R8 keep", 4'd3, 4'd4, 4'd3, 4'd0, 1'b1, 3'd2, 4'b0111, 3'd1, 1'b1);
    directed("R8 corner", 4'd3, 4'd4, 4'd3, 4'd0, 1'b1, 3'd2, 4'hF, 3'd4, 1'b0);
    directed("R9 no return", 4'd3, 4'd3, 4'd5, 4'd3, 1'b1, 3'd1, 4'hF, 3'd3, 1'b1);
    directed("R10 pin edge", 4'd5, 4'd3, 4'd7, 4'd3, 1'b0, 3'd0, 4'h0, 3'd1, 1'b0);
    directed("R10 off east", 4'd3, 4'd3, 4'd5, 4'd3, 1'b0, 3'd0, 4'b1110, 3'd3, 1'b1);
    directed("R11 stall marked", 4'd3, 4'd3, 4'd5, 4'd5, 1'b1, 3'd0, 4'h0, 3'd5, 1'b1);
    directed("R11 stall clear", 4'd3, 4'd3, 4'd5, 4'd5, 1'b0, 3'd0, 4'h0, 3'd5, 1'b0);

    // R2: idle cycle yields no grant and keeps the previous decision
    route(4'd1, 4'd1, 4'd4, 4'd1, 1'b0, 3'd0, 4'hF, lastp, lasts, g);
    @(negedge clk);
    own_x = 4'd3; dst_x = 4'd0; nbr_act = 4'h0; stamp_in = 1'b1;
    @(negedge clk);
    check(gnt == 1'b0, "R2 idle gnt", gnt, 0);
    check(out_port == lastp, "R2 idle port hold", out_port, lastp);
    check(stamp_out == lasts, "R2 idle mark hold", stamp_out, lasts);

    // Random single decisions against the bench model
    for (int i = 0; i < 400; i++) begin
      logic [3:0] ox, oy, dx, dy, na;
      logic st;
      logic [2:0] ar;
      ox = 4'($urandom_range(0, 15)); oy = 4'($urandom_range(0, 15));
      dx = ($urandom_range(0, 7) == 0) ? ox : 4'($urandom_range(0, 15));
      dy = ($urandom_range(0, 7) == 0) ? oy : 4'($urandom_range(0, 15));
      st = 1'($urandom_range(0, 1));
      ar = 3'($urandom_range(0, 4));
      na = 4'($urandom_range(0, 15));
      exp = ref_route(ox, oy, dx, dy, st, ar, na);
      route(ox, oy, dx, dy, st, ar, na, p, s, g);
      check(g && p == exp[2:0], "R4-model random port", p, exp[2:0]);
      check(s == exp[3], "R5-model random mark", s, exp[3]);
    end

    // R12: whole routes through a mesh with a switched-off block
    for (int sx = 0; sx < MX; sx++)
      for (int sy = 0; sy < MY; sy++)
        for (int tx = 0; tx < MX; tx++)
          for (int ty = 0; ty < MY; ty++) begin
            int x, y, hops;
            logic cst;
            logic [2:0] car;
            bit done;
            if (!alive(sx, sy) || !alive(tx, ty)) continue;
            x = sx; y = sy; cst = 1'b0; car = 3'd0; done = 1'b0; hops = 0;
            while (!done && hops <= HOP_MAX) begin
              exp = ref_route(4'(x), 4'(y), 4'(tx), 4'(ty), cst, car, nbrs_of(x, y));
              route(4'(x), 4'(y), 4'(tx), 4'(ty), cst, car, nbrs_of(x, y), p, s, g);
              if (p != exp[2:0] || s != exp[3])
                check(1'b0, "R12 hop decision", p, exp[2:0]);
              if (cst && car != 3'd0 && p == car)
                check(1'b0, "R9 hop reversal", p, 9);
              if (p == 3'd0 || p == 3'd5) begin
                done = 1'b1;
              end else begin
                case (p)
                  3'd1: x = x + 1;
                  3'd2: x = x - 1;
                  3'd3: y = y + 1;
                  default: y = y - 1;
                endcase
                if (!alive(x, y)) begin
                  check(1'b0, "R10 hop entered switched-off router", p, 0);
                  done = 1'b1;
                end
                car = t_opp(p);
                cst = s;
                hops++;
              end
            end
            check(p == 3'd0 && x == tx && y == ty && hops <= HOP_MAX,
                  "R12 reached destination", hops, HOP_MAX);
          end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule